// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This block is a register-mapped timer with a number of independent 32-bit channels. Each channel counts down from a programmed reload value. When the count passes through zero, the channel sets its event flag, reloads itself and keeps running. There is no one-shot mode. Software reaches the block through a simple synchronous register port: one request per cycle, with a write strobe. Read data comes back one cycle later with a valid pulse. Each channel has its own interrupt line.

A channel may be switched into cascade mode. It then advances only when its lower neighbour expires, so two channels together act as one wide counter. A global halt bit in the module control word freezes every channel. A new reload value never cuts a running period short. Software restarts a period by clearing the run bit and then setting it again. The 0-to-1 transition of the run bit copies the reload value into the counter.

Top module: `itmr_core`

## Requirements
- R1: After reset every register reads zero and every interrupt line is low.
- R2: Register map. The module control word is at 0x000, and its bit 1 is the halt bit. Channel n starts at 0x100 + 0x10*n. Within a channel, reload is at +0x0, live count at +0x4, control at +0x8 and the event flag at +0xC. Control bits: bit 0 run, bit 1 interrupt enable, bit 2 cascade. The flag is bit 0. A read request gives `bus_rvalid` high on the next cycle. `bus_rdata` then carries the value the register held when the request was sampled.
- R3: With reload value N, a running channel expires every N+1 clock cycles. On each expiry it reloads from the reload register and continues.
- R4: A write that moves the run bit from 0 to 1 loads the counter from the reload register. A stopped channel holds its count.
- R5: Writing the reload register while a channel runs leaves the live count untouched. The new value is used from the next reload onward.
- R6: Expiry sets the event flag. Writing 1 to flag bit 0 clears it. If an expiry and a clear fall in the same cycle, the flag stays set.
- R7: A channel's interrupt line is high exactly when its flag and its interrupt-enable bit are both set.
- R8: In cascade mode, channel n+1 steps once per expiry of channel n instead of once per clock. The cascade bit has no effect on channel 0.
- R9: While the halt bit is set, no channel counts or expires.
- R10: Writes to a live-count register are ignored. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (9) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | NCH (4) | Per-channel interrupt lines |

## Verification
The assertions assume that a request on the register port lasts exactly one cycle. They also assume that every read is answered on the following cycle, with no stalls. The stability checks for stopped or halted counters apply only in cycles without a write, because a run-bit write may legally reload the counter. The bench drives at most one request per cycle. It always issues requests on the falling edge, so each access lands on exactly one rising edge. Expected expiry times are counted edge by edge from that access.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned IEN_BIT   = 1;
  localparam int unsigned CASC_BIT  = 2;
  localparam int unsigned HALT_BIT  = 1;
  localparam int unsigned FLAG_BIT  = 0;
  localparam int unsigned CH_ROW0   = 16;  // 0x100 >> 4

  typedef enum logic [1:0] {
    FLD_RELOAD = 2'd0,
    FLD_COUNT  = 2'd1,
    FLD_CTRL   = 2'd2,
    FLD_FLAG   = 2'd3
  } field_e;

  typedef struct packed {
    logic casc;
    logic ien;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
  import itmr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 9
) (
  input  logic [AW-1:0]  addr,
  output logic           is_modctl,
  output logic [NCH-1:0] chan_hit,
  output field_e         field
);
  localparam int unsigned ROW_W = AW - 4;

  assign is_modctl = (addr == '0);
  assign field     = field_e'(addr[3:2]);

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign chan_hit[i] = (addr[AW-1:4] == ROW_W'(CH_ROW0 + i)) && (addr[1:0] == 2'b00);
  end
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_reload,
  input  logic          wr_ctrl,
  input  logic          wr_flag,
  input  logic [DW-1:0] wdata,
  input  logic          halt,
  input  logic          step,
  output logic [DW-1:0] reload_q,
  output logic [DW-1:0] count_q,
  output ctrl_t         ctrl_q,
  output logic          flag_q,
  output logic          expire,
  output logic          irq
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic advance;
  logic start;

  assign advance = ctrl_q.run && !halt && step;
  assign expire  = advance && (count_q == '0);
  assign start   = wr_ctrl && wdata[RUN_BIT] && !ctrl_q.run;
  assign irq     = flag_q && ctrl_q.ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q.run  <= wdata[RUN_BIT];
        ctrl_q.ien  <= wdata[IEN_BIT];
        ctrl_q.casc <= wdata[CASC_BIT];
      end
      if (start)        count_q <= reload_q;
      else if (expire)  count_q <= reload_q;
      else if (advance) count_q <= count_q - ONE;
      if (expire)                          flag_q <= 1'b1;
      else if (wr_flag && wdata[FLAG_BIT]) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/itmr_core.sv
module itmr_core
  import itmr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  output logic [NCH-1:0] irq
);
  logic                    is_modctl;
  logic [NCH-1:0]          chan_hit;
  field_e                  field;
  logic                    wr_en;
  logic                    rd_en;
  logic                    halt_q;
  logic [NCH-1:0]          flag_v;
  logic [NCH-1:0]          run_v;
  logic [NCH-1:0]          exp_v;
  logic [NCH-1:0]          step_v;
  logic [NCH-1:0][DW-1:0]  cnt_v;
  logic [NCH-1:0][DW-1:0]  load_v;
  ctrl_t [NCH-1:0]         ctrl_v;
  logic [DW-1:0]           rd_next;

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  itmr_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr      (bus_addr),
    .is_modctl (is_modctl),
    .chan_hit  (chan_hit),
    .field     (field)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  halt_q <= 1'b0;
    else if (wr_en && is_modctl) halt_q <= bus_wdata[HALT_BIT];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_first
      assign step_v[i] = 1'b1;
    end else begin : g_next
      assign step_v[i] = ctrl_v[i].casc ? exp_v[i-1] : 1'b1;
    end

    itmr_channel #(.DW(DW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_reload (wr_en && chan_hit[i] && (field == FLD_RELOAD)),
      .wr_ctrl   (wr_en && chan_hit[i] && (field == FLD_CTRL)),
      .wr_flag   (wr_en && chan_hit[i] && (field == FLD_FLAG)),
      .wdata     (bus_wdata),
      .halt      (halt_q),
      .step      (step_v[i]),
      .reload_q  (load_v[i]),
      .count_q   (cnt_v[i]),
      .ctrl_q    (ctrl_v[i]),
      .flag_q    (flag_v[i]),
      .expire    (exp_v[i]),
      .irq       (irq[i])
    );
    assign run_v[i] = ctrl_v[i].run;
  end

  always_comb begin
    rd_next = '0;
    if (is_modctl) rd_next[HALT_BIT] = halt_q;
    for (int i = 0; i < NCH; i++) begin
      if (chan_hit[i]) begin
        unique case (field)
          FLD_RELOAD: rd_next = load_v[i];
          FLD_COUNT:  rd_next = cnt_v[i];
          FLD_CTRL:   rd_next[2:0] = ctrl_v[i];
          FLD_FLAG:   rd_next[FLAG_BIT] = flag_v[i];
          default:    rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic                   bus_rvalid,
  input logic                   halt_q,
  input logic [NCH-1:0]         run_v,
  input logic [NCH-1:0]         flag_v,
  input logic [NCH-1:0]         exp_v,
  input logic [NCH-1:0][DW-1:0] cnt_v,
  input logic [NCH-1:0][DW-1:0] load_v
);
  logic wr;
  assign wr = bus_valid && bus_write;

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);  // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);  // R2
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr) |=> $stable(cnt_v));  // R9

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_RELOAD_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] |=> (cnt_v[i] == $past(load_v[i])));  // R3
    AST_FLAG_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] |=> flag_v[i]);  // R6
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_v[i] && !wr) |=> $stable(cnt_v[i]));  // R4
  end
endmodule

bind itmr_core itmr_checker #(.NCH(NCH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_rvalid (bus_rvalid),
  .halt_q     (halt_q),
  .run_v      (run_v),
  .flag_v     (flag_v),
  .exp_v      (exp_v),
  .cnt_v      (cnt_v),
  .load_v     (load_v)
);

// File: tb/itmr_core_test.sv
module itmr_core_test;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 9;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_valid = 1'b0;
  logic           bus_write = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [DW-1:0]  bus_wdata = '0;
  logic [DW-1:0]  bus_rdata;
  logic           bus_rvalid;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  itmr_core #(.NCH(NCH), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  function automatic logic [AW-1:0] ch_addr(int ch, int off);
    return AW'(256 + 16 * ch + off);
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] expv, string req);
    exp_q.push_back(expv);
    tag_q.push_back(req);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(int ch, logic expv, string req);
    check(irq[ch] == expv, req, DW'(irq[ch]), DW'(expv));
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected rvalid", bus_rdata, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(1);

    // R1 reset state
    chk_irq(0, 1'b0, "R1 irq0");
    check(irq == '0, "R1 irq all", DW'(irq), '0);
    rd(9'h000, 32'h0, "R1 modctl");
    rd(ch_addr(0, 0), 32'h0, "R1 reload0");
    rd(ch_addr(0, 8), 32'h0, "R1 ctrl0");
    rd(ch_addr(0, 4), 32'h0, "R1 count0");
    rd(ch_addr(3, 12), 32'h0, "R1 flag3");

    // R3 period of N+1, R8 cascade bit ignored on channel 0
    wr(ch_addr(0, 0), 32'd4);
    wr(ch_addr(0, 8), 32'd7);
    ticks(4); chk_irq(0, 1'b0, "R3 before first expiry");
    ticks(1); chk_irq(0, 1'b1, "R3 first expiry / R8 ch0");
    wr(ch_addr(0, 12), 32'd1); chk_irq(0, 1'b0, "R6 clear");
    ticks(3); chk_irq(0, 1'b0, "R3 before second expiry");
    ticks(1); chk_irq(0, 1'b1, "R3 second expiry after N+1");

    // R4 / R5 channel 1: stop holds count, reload write does not disturb
    wr(ch_addr(1, 0), 32'd100);
    wr(ch_addr(1, 8), 32'd1);
    ticks(10);
    wr(ch_addr(1, 8), 32'd0);
    wr(ch_addr(1, 0), 32'd7);
    rd(ch_addr(1, 4), 32'd89, "R4 stopped count held");
    wr(ch_addr(1, 8), 32'd1);
    rd(ch_addr(1, 4), 32'd7, "R4 restart loads reload");

    // R5 running channel 2 keeps its period
    wr(ch_addr(2, 0), 32'd2);
    wr(ch_addr(2, 8), 32'd3);
    wr(ch_addr(2, 0), 32'd50);
    ticks(1); chk_irq(2, 1'b0, "R5 before expiry");
    ticks(1); chk_irq(2, 1'b1, "R5 old count expires");
    wr(ch_addr(2, 12), 32'd1);
    wr(ch_addr(2, 8), 32'd0);
    rd(ch_addr(2, 4), 32'd48, "R5 reload used new value");

    // R8 cascade: channel 1 steps on channel 0 expiries
    wr(ch_addr(1, 8), 32'd0);
    wr(ch_addr(1, 12), 32'd1);
    wr(ch_addr(1, 0), 32'd2);
    wr(ch_addr(0, 8), 32'd0);
    wr(ch_addr(0, 0), 32'd1);
    wr(ch_addr(1, 8), 32'd7);
    wr(ch_addr(0, 8), 32'd1);
    ticks(4); chk_irq(1, 1'b0, "R8 cascade early");
    ticks(1); chk_irq(1, 1'b0, "R8 cascade not yet");
    ticks(1); chk_irq(1, 1'b1, "R8 cascade expiry");
    chk_irq(0, 1'b0, "R7 flag without enable");
    rd(ch_addr(0, 12), 32'd1, "R7 flag0 set");

    // R9 halt
    wr(9'h000, 32'd2);
    rd(9'h000, 32'd2, "R2 halt readback");
    wr(ch_addr(3, 0), 32'd3);
    wr(ch_addr(3, 8), 32'd3);
    ticks(10); chk_irq(3, 1'b0, "R9 no expiry while halted");
    rd(ch_addr(3, 4), 32'd3, "R9 count frozen");
    wr(9'h000, 32'd0);
    ticks(3); chk_irq(3, 1'b0, "R9 resumed early");
    ticks(1); chk_irq(3, 1'b1, "R9 resumed expiry");

    // R6 set wins over clear
    ticks(3);
    wr(ch_addr(3, 12), 32'd1); chk_irq(3, 1'b1, "R6 set beats clear");
    wr(ch_addr(3, 12), 32'd1); chk_irq(3, 1'b0, "R6 clear later");

    // R10 ignored writes and unmapped reads
    wr(ch_addr(3, 8), 32'd0);
    wr(ch_addr(3, 4), 32'h55);
    rd(ch_addr(3, 4), 32'd1, "R10 count write ignored");
    rd(9'h004, 32'h0, "R10 unmapped 0x004");
    rd(9'h140, 32'h0, "R10 unmapped 0x140");
    rd(ch_addr(2, 0), 32'd50, "R2 reload2 readback");
    rd(ch_addr(0, 8), 32'd1, "R2 ctrl0 readback");

    ticks(3);
    check(exp_q.size() == 0, "R2 reads all answered", DW'(exp_q.size()), '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule